// File: doc/BRIEF.md
# SMBus Register-Pointer Target

This block is the target side of a two-wire SMBus link. It gives a host byte-wide read and write access to a register file that sits outside the block. The block takes SCL and SDA samples that are already synchronized to the system clock. It recognises start, repeated-start and stop conditions. It compares the 7-bit target address with its own address and acknowledges each byte it accepts. It pulls SDA low through an open-drain enable.

In a write transaction, the first data byte sets a persistent register pointer. Each further byte in that transaction is written to the register the pointer selects. The pointer does not advance, so consecutive data bytes all land on the same register. A read transaction returns the register the pointer selects, MSB first, and repeats that register for as long as the host keeps acknowledging. The block's own address is the base 0x50 plus a 3-bit location code, and the code is captured only while reset is active. A clock-low timeout, enabled by an input that a configuration register bit drives, returns the bus engine to idle after SCL has been held low too long.

Top module: `smb_regport`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. After a stop the block ignores all clocking, and does not acknowledge, until the next start.
- R2: The target address is 0x50 plus `locCode` (so codes 0 to 3 give 0x50 to 0x53). The code is sampled only while `rstN` is low, and later changes on `locCode` have no effect.
- R3: When the 7-bit address (received MSB first, followed by the R/W bit) matches, SDA is held low during the 9th clock. When it does not match, the block drives nothing and writes nothing until the next start.
- R4: In a write (R/W = 0), the first data byte loads the pointer. Every later byte produces a one-cycle `regWe` pulse with `regAddr` equal to the pointer, so all later bytes go to the same register. Each byte is acknowledged.
- R5: In a read (R/W = 1), the byte sent is the register the pointer selects. The pointer keeps its value across transactions and is 0x00 after reset.
- R6: Read data is driven MSB first. When the host acknowledges, the same register is sent again. When the host does not acknowledge (SDA high in the 9th clock), SDA is released and stays released until the next start.
- R7: A repeated start, with no stop before it, returns the block to address reception. This allows a pointer write followed by a read.
- R8: When `tmoEn` is 1 and SCL stays low for TMO_CYCLES system clocks during a transaction, the block returns to idle. When `tmoEn` is 0, an SCL low time of any length has no effect.
- R9: `sdaOe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset; `locCode` is captured while it is low |
| sclIn | input | 1 | Synchronized bus clock level |
| sdaIn | input | 1 | Synchronized bus data level (wired-AND line) |
| tmoEn | input | 1 | Enables the clock-low timeout (configuration bit, low after reset) |
| locCode | input | 3 | Location code that selects the target address |
| sdaOe | output | 1 | 1 pulls SDA low |
| regAddr | output | 8 | Register pointer, used as the register file address |
| regWdata | output | 8 | Write data for the register file |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Register file read data, combinational from `regAddr` |

## Verification
The assertions assume a host that follows the bus rules. The host changes SDA only while SCL is low, except when it forms a start or a stop. It never issues a start while the target is pulling SDA low, and every SCL phase lasts several system clocks, well below the timeout. The bench's host tasks hold each SCL phase for eight system clocks and change data only in the low phase. Repeated starts are placed only after a written byte, when the line is free. The bench models the wired-AND line itself, so the block reads back its own drive exactly as it would see it on a real bus.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WRITE,
    S_READ,
    S_SKIP
  } busState_t;

  // strobes from control to datapath, each valid for one cycle
  typedef struct packed {
    logic shiftRx;
    logic loadTx;
    logic shiftTx;
    logic loadPtr;
    logic wrReg;
    logic ackSet;
    logic drvClr;
  } ctlStrb_t;
endpackage

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
#(
  parameter int unsigned TMO_CYCLES = 7500000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclIn,
  input  logic     sdaIn,
  input  logic     tmoEn,
  input  logic     addrHit,
  input  logic     rwBit,
  output ctlStrb_t strb
);
  localparam int unsigned CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYCLES - 1);

  logic sclQ, sdaQ;
  logic startEv, stopEv, sclRise, sclFall;
  busState_t state, stateN;
  logic [3:0] bitCnt, bitN;
  logic firstByte, firstN;
  logic [CNT_W-1:0] tmoCnt;
  logic tmoHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign startEv = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopEv  = sclIn & sclQ & ~sdaQ & sdaIn;
  assign sclRise = sclIn & ~sclQ;
  assign sclFall = ~sclIn & sclQ;

  // clock-low watchdog, only meaningful inside a transaction
  assign tmoHit = tmoEn && (state != S_IDLE) && !sclIn && (tmoCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || sclIn || state == S_IDLE || tmoHit) tmoCnt <= '0;
    else if (tmoCnt != CNT_LAST) tmoCnt <= tmoCnt + 1'b1;
  end

  always_comb begin
    strb   = '0;
    stateN = state;
    bitN   = bitCnt;
    firstN = firstByte;
    if (tmoHit) begin
      stateN = S_IDLE;
      strb.drvClr = 1'b1;
    end else if (startEv) begin
      stateN = S_ADDR;
      bitN   = 4'd0;
      strb.drvClr = 1'b1;
    end else if (stopEv) begin
      stateN = S_IDLE;
      strb.drvClr = 1'b1;
    end else if (state != S_IDLE && state != S_SKIP) begin
      if (sclRise) begin
        if (bitCnt != 4'd8) begin
          strb.shiftRx = 1'b1;
          bitN = bitCnt + 4'd1;
        end else begin
          bitN = 4'd0;
          case (state)
            S_ADDR: begin
              stateN = rwBit ? S_READ : S_WRITE;
              firstN = 1'b1;
            end
            S_READ:  if (sdaIn) stateN = S_SKIP;
            default: ;
          endcase
        end
      end else if (sclFall) begin
        if (bitCnt == 4'd8) begin
          case (state)
            S_ADDR: begin
              if (addrHit) strb.ackSet = 1'b1;
              else stateN = S_SKIP;
            end
            S_WRITE: begin
              strb.ackSet = 1'b1;
              if (firstByte) strb.loadPtr = 1'b1;
              else strb.wrReg = 1'b1;
              firstN = 1'b0;
            end
            default: strb.drvClr = 1'b1;  // hand the 9th clock to the host
          endcase
        end else if (bitCnt == 4'd0) begin
          strb.drvClr = 1'b1;
          if (state == S_READ) strb.loadTx = 1'b1;
        end else if (state == S_READ) begin
          strb.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= 4'd0;
      firstByte <= 1'b0;
    end else begin
      state     <= stateN;
      bitCnt    <= bitN;
      firstByte <= firstN;
    end
  end

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> state == S_IDLE);

  p_start_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startEv && !tmoHit) |=> (state == S_ADDR && bitCnt == 4'd0));

  p_nack_skip_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && sclRise && bitCnt == 4'd8 && sdaIn && !tmoHit)
      |=> state == S_SKIP);

  p_tmo_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    tmoHit |=> state == S_IDLE);
endmodule

// File: rtl/smb_dpath.sv
module smb_dpath
  import smb_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h50,
  parameter int unsigned LOC_W = 3,
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaIn,
  input  logic [LOC_W-1:0] locCode,
  input  ctlStrb_t         strb,
  output logic             addrHit,
  output logic             rwBit,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWdata,
  output logic             regWe,
  input  logic [7:0]       regRdata,
  output logic             sdaOe
);
  localparam int unsigned BYTE_W = 8;

  logic [6:0] ownAddr;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0] pointer;
  logic ackDrv, txActive;

  // the address is fixed from the code seen during reset
  always_ff @(posedge clk) begin
    if (!rstN) ownAddr <= ADDR_BASE + 7'(locCode);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '0;
    else if (strb.shiftRx) rxShift <= {rxShift[BYTE_W-2:0], sdaIn};
  end

  assign addrHit = (rxShift[BYTE_W-1:1] == ownAddr);
  assign rwBit   = rxShift[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pointer  <= '0;
      regWe    <= 1'b0;
      regWdata <= '0;
    end else begin
      regWe <= strb.wrReg;
      if (strb.loadPtr) pointer <= rxShift[PTR_W-1:0];
      if (strb.wrReg) regWdata <= rxShift;
    end
  end

  assign regAddr = pointer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackDrv   <= 1'b0;
      txActive <= 1'b0;
      txShift  <= '0;
    end else begin
      if (strb.drvClr) begin
        ackDrv   <= 1'b0;
        txActive <= 1'b0;
      end
      if (strb.ackSet) ackDrv <= 1'b1;
      if (strb.loadTx) begin
        txShift  <= regRdata;
        txActive <= 1'b1;
      end else if (strb.shiftTx) begin
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign sdaOe = ackDrv | (txActive & ~txShift[BYTE_W-1]);

  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  p_ack_tx_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrv && txActive));

  p_own_addr_fixed_r2: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ownAddr));
endmodule

// File: rtl/smb_regport.sv
module smb_regport #(
  parameter logic [6:0] ADDR_BASE = 7'h50,
  parameter int unsigned LOC_W = 3,
  parameter int unsigned PTR_W = 8,
  parameter int unsigned TMO_CYCLES = 7500000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             tmoEn,
  input  logic [LOC_W-1:0] locCode,
  output logic             sdaOe,
  output logic [PTR_W-1:0] regAddr,
  output logic [7:0]       regWdata,
  output logic             regWe,
  input  logic [7:0]       regRdata
);
  import smb_pkg::*;

  ctlStrb_t strb;
  logic addrHit, rwBit;

  smb_ctrl #(.TMO_CYCLES(TMO_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .tmoEn(tmoEn),
    .addrHit(addrHit), .rwBit(rwBit), .strb(strb)
  );

  smb_dpath #(.ADDR_BASE(ADDR_BASE), .LOC_W(LOC_W), .PTR_W(PTR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sdaIn(sdaIn), .locCode(locCode), .strb(strb),
    .addrHit(addrHit), .rwBit(rwBit), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .sdaOe(sdaOe)
  );

  p_sda_steady_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));
endmodule

// File: tb/smb_regport_test.sv
module smb_regport_test;
  localparam int H = 8;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic hostSda = 1'b1;
  logic tmoEn = 1'b0;
  logic [2:0] loc = 3'd0;
  logic sdaOe, regWe;
  logic [7:0] regAddr, regWdata, regRdata;
  logic sdaLine;
  logic [7:0] mem [256];
  int weCnt = 0;
  int checks = 0;
  int errors = 0;
  int r9Viol = 0;
  logic sclPrev = 1'b1;
  logic oePrev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sdaLine  = hostSda & ~sdaOe;
  assign regRdata = mem[regAddr];

  smb_regport #(.TMO_CYCLES(TMO)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .tmoEn(tmoEn),
    .locCode(loc), .sdaOe(sdaOe), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata)
  );

  always @(posedge clk) begin
    if (regWe) begin
      mem[regAddr] <= regWdata;
      weCnt <= weCnt + 1;
    end
    if (rstN && scl && sclPrev && sdaOe != oePrev) r9Viol <= r9Viol + 1;
    sclPrev <= scl;
    oePrev  <= sdaOe;
  end

  // pointer / data pairs
  localparam logic [15:0] VEC [5] = '{16'h00A5, 16'h0712, 16'h3C5A, 16'h80FF, 16'hFE01};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hp();
    repeat (H) @(negedge clk);
  endtask

  task automatic doReset(input logic [2:0] code);
    rstN = 1'b0; loc = code; scl = 1'b1; hostSda = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic clkBit(input logic b, output logic s);
    hostSda = b; hp();
    scl = 1'b1; hp();
    s = sdaLine;
    scl = 1'b0; hp();
  endtask

  task automatic busStart();
    hostSda = 1'b1; hp();
    scl = 1'b1; hp();
    hostSda = 1'b0; hp();
    scl = 1'b0; hp();
  endtask

  task automatic busStop();
    hostSda = 1'b0; hp();
    scl = 1'b1; hp();
    hostSda = 1'b1; hp();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clkBit(b[i], s);
    clkBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clkBit(1'b1, s);
      d[i] = s;
    end
    clkBit(~ackIt, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int wc;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[0] = 8'h77;
    doReset(3'd0);
    chk(sdaOe == 1'b0, "R1 reset sdaOe", sdaOe, 0);
    chk(regWe == 1'b0, "R4 reset regWe", regWe, 0);

    // R5: pointer starts at 0x00
    busStart(); sendByte(8'hA1, a); readByte(1'b0, d); busStop();
    chk(a == 1'b1, "R3 read address ack", a, 1);
    chk(d == 8'h77, "R5 reset pointer read", d, 8'h77);

    // vector table walk: write pair, then read without pointer write
    for (int v = 0; v < 5; v++) begin
      logic a0, a1, a2;
      busStart(); sendByte(8'hA0, a0); sendByte(VEC[v][15:8], a1); sendByte(VEC[v][7:0], a2); busStop();
      chk(a0 & a1 & a2, "R4 write acks", {a0, a1, a2}, 3'b111);
      chk(mem[VEC[v][15:8]] == VEC[v][7:0], "R4 write data", mem[VEC[v][15:8]], VEC[v][7:0]);
      busStart(); sendByte(8'hA1, a0); readByte(1'b0, d);
      repeat (3) @(negedge clk);
      chk(sdaOe == 1'b0, "R6 release after NACK", sdaOe, 0);
      busStop();
      chk(d == VEC[v][7:0], "R5 read at pointer", d, VEC[v][7:0]);
    end

    // R4: several data bytes hit the same register
    wc = weCnt;
    busStart(); sendByte(8'hA0, a); sendByte(8'h10, a); sendByte(8'h11, a); sendByte(8'h22, a); busStop();
    chk(mem[8'h10] == 8'h22, "R4 same register", mem[8'h10], 8'h22);
    chk(weCnt - wc == 2, "R4 strobe count", weCnt - wc, 2);

    // R3: foreign address is ignored
    wc = weCnt;
    busStart(); sendByte(8'hA2, a);
    chk(a == 1'b0, "R3 no ack foreign", a, 0);
    sendByte(8'h20, a); sendByte(8'h99, a); busStop();
    chk(a == 1'b0, "R3 data not acked", a, 0);
    chk(weCnt == wc, "R3 no write", weCnt - wc, 0);
    chk(mem[8'h20] == 8'h00, "R3 register untouched", mem[8'h20], 0);

    // R7: pointer write, repeated start, read
    busStart(); sendByte(8'hA0, a); sendByte(8'h07, a);
    busStart(); sendByte(8'hA1, a);
    chk(a == 1'b1, "R7 ack after repeated start", a, 1);
    readByte(1'b0, d); busStop();
    chk(d == 8'h12, "R7 read after repeated start", d, 8'h12);

    // R5/R6: pointer persists; host ACK repeats the register
    busStart(); sendByte(8'hA1, a); readByte(1'b1, d);
    chk(d == 8'h12, "R6 first of two", d, 8'h12);
    readByte(1'b0, d); busStop();
    chk(d == 8'h12, "R5 R6 second of two", d, 8'h12);

    // R2: code change after reset has no effect
    loc = 3'd5; repeat (4) @(negedge clk);
    busStart(); sendByte(8'hAA, a); busStop();
    chk(a == 1'b0, "R2 new code ignored", a, 0);
    busStart(); sendByte(8'hA0, a); busStop();
    chk(a == 1'b1, "R2 old address kept", a, 1);
    doReset(3'd3);
    busStart(); sendByte(8'hA6, a); busStop();
    chk(a == 1'b1, "R2 code 3 address 0x53", a, 1);
    busStart(); sendByte(8'hA0, a); busStop();
    chk(a == 1'b0, "R2 0x50 after code 3", a, 0);

    // R8: timeout enabled
    tmoEn = 1'b1;
    busStart(); sendByte(8'hA6, a);
    repeat (TMO + 100) @(negedge clk);
    sendByte(8'h30, a); busStop();
    chk(a == 1'b0, "R8 timeout returns idle", a, 0);
    // R8: timeout disabled
    tmoEn = 1'b0;
    busStart(); sendByte(8'hA6, a);
    repeat (TMO + 100) @(negedge clk);
    sendByte(8'h30, a);
    chk(a == 1'b1, "R8 disabled no effect", a, 1);
    sendByte(8'h44, a); busStop();
    chk(mem[8'h30] == 8'h44, "R8 write after long low", mem[8'h30], 8'h44);

    // R1: after a stop, bytes without a start are ignored
    busStart(); sendByte(8'hA6, a); busStop();
    sendByte(8'hA6, a);
    chk(a == 1'b0, "R1 no start no ack", a, 0);
    busStart(); busStop();

    chk(r9Viol == 0, "R9 sdaOe steady while SCL high", r9Viol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule